// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block is a built-in self-test controller for one RAM segment of 2^AW words of DW bits (64K x 16 by default). The segment is reached through a single-port read/write interface whose reads return data one cycle after they are issued. A start pulse launches a fixed run of three phases. The first is an address-line probe. The second is a pass over the whole segment with four word patterns. The third is a replayed pseudo-random address phase. A parity-error flag collected during these phases is then consulted. When the run passes, the segment is cleared to zero before the result is reported.

The controller stops at the first wrong read word. It reports which phase failed and the address of the failing word, and it leaves the memory as it stood at that point. When the skip request is high together with start, the controller only writes zero over every word and reports a pass.

Top module: `memtest_engine`

## Requirements
- R1: After reset, done, busy, mem_we and mem_re are all low, and no memory access occurs until start is seen.
- R2: Address-line phase:
  - Test data 0xC35A is written at address 0.
  - For each bit k from 0 to AW-1 in turn, 0x00FF is written at address 2^k and read back, then 0x0000 is written there and read back.
  - Finally, address 0 is read back.
  - A wrong probe read fails with fail_phase 0 and that probe address. A corrupted test word at address 0 fails with fail_phase 0 and fail_addr 0.
- R3: Pattern phase:
  - The patterns 0x8080, 0x5555, 0x3333 and 0x0F0F are used, in that order.
  - For each pattern, every address is written in ascending order, and then every address is read back in ascending order.
  - A wrong word fails with fail_phase 1 and its address.
- R4: Random phase:
  - The address source is a right-shifting Galois LFSR of AW bits. It starts at 1 and uses feedback mask 0xB8 for AW=8 or 0xB400 for AW=16.
  - N_RAND words are written, each at the current LFSR address. The data is the LFSR's low byte, zero-extended.
  - The LFSR is then restarted and the same addresses are read back in the same order.
  - A read that differs from its byte fails with fail_phase 2 and that address.
- R5: A parity-error pulse on par_err at any cycle of a test run causes a fail with fail_phase 3 and fail_addr 0, and no clearing takes place. A pulse while the block is idle is ignored.
- R6: A run that passes ends by writing zero at every address in ascending order. Only then does done rise with pass high.
- R7: A start with skip high writes zero at all 2^AW addresses, issues no read, and ends with done and pass high.
- R8: The first wrong read ends the run. From then on, no further write or read is issued and the memory keeps its contents.
- R9: A read and a write are never issued in the same cycle. Each read word is compared in the cycle after its read strobe.
- R10: busy is high from the cycle after start until done rises. done, pass, fail_phase and fail_addr then hold until the next start, after which a new run proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run (sampled while idle or done) |
| skip | input | 1 | With start: clear the segment only |
| par_err | input | 1 | Parity error seen by the memory |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; status valid |
| pass | output | 1 | Run passed |
| fail_phase | output | 2 | 0 address, 1 pattern, 2 random, 3 parity |
| fail_addr | output | AW | Address of the failing word |

## Verification
The assertions assume that start arrives only while the block is idle or done. They also assume that mem_rdata follows each read strobe by exactly one cycle. The RAM model in the bench honours that latency, and the bench raises start only after done or reset. Faults are injected as a stuck address bit, a stuck data bit at one word and a write that also lands on a second word, so every failure path is reached without breaking the read-latency assumption.

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int N_RAND    = 16384,
  parameter logic [15:0] TEST_WORD = 16'hC35A,
  parameter logic [15:0] LFSR_INIT = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          skip,
  input  logic          par_err,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [1:0]    fail_phase,
  output logic [AW-1:0] fail_addr
);

  function automatic logic [15:0] taps_for(input int w);
    case (w)
      8:  return 16'h00B8;
      9:  return 16'h0110;
      10: return 16'h0240;
      11: return 16'h0500;
      12: return 16'h0E08;
      13: return 16'h1C80;
      14: return 16'h3802;
      15: return 16'h6000;
      default: return 16'hB400;
    endcase
  endfunction

  function automatic logic [DW-1:0] pat_of(input logic [1:0] s);
    case (s)
      2'd0: return DW'(16'h8080);
      2'd1: return DW'(16'h5555);
      2'd2: return DW'(16'h3333);
      default: return DW'(16'h0F0F);
    endcase
  endfunction

  localparam int BKW = $clog2(AW);
  localparam int RCW = $clog2(N_RAND) + 1;
  localparam logic [AW-1:0] TAPS  = AW'(taps_for(AW));
  localparam logic [AW-1:0] START = AW'(LFSR_INIT);
  localparam logic [AW-1:0] LAST  = {AW{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_SENT, S_AW1, S_AR1, S_AW0, S_AR0, S_ACHK,
    S_SW, S_SR, S_RW, S_RR, S_PAR, S_CLR, S_DONE
  } st_t;

  st_t            st;
  logic [AW-1:0]  addr, lfsr, chk_addr, fad;
  logic [BKW-1:0] bk;
  logic [1:0]     psel, chk_ph, fph;
  logic [RCW-1:0] rcnt;
  logic [DW-1:0]  chk_exp, exp_c;
  logic [1:0]     ph_c;
  logic           chk_v, par_seen, skip_q, done_q, pass_q;

  wire [AW-1:0] probe    = AW'(1) << bk;
  wire [DW-1:0] seed     = DW'(lfsr[7:0]);
  wire [AW-1:0] lfsr_nx  = (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
  wire          mismatch = chk_v && (mem_rdata != chk_exp);
  wire          testing  = (st != S_IDLE) && (st != S_DONE) && (st != S_CLR);
  wire          rnd_end  = (rcnt == RCW'(N_RAND - 1));

  assign busy       = (st != S_IDLE) && (st != S_DONE);
  assign done       = done_q;
  assign pass       = pass_q;
  assign fail_phase = fph;
  assign fail_addr  = fad;

  always_comb begin
    mem_we = 1'b0; mem_re = 1'b0; mem_addr = '0; mem_wdata = '0;
    exp_c = '0; ph_c = 2'd0;
    case (st)
      S_SENT: begin mem_we = 1'b1; mem_wdata = DW'(TEST_WORD); end
      S_AW1:  begin mem_we = 1'b1; mem_addr = probe; mem_wdata = DW'(8'hFF); end
      S_AR1:  begin mem_re = 1'b1; mem_addr = probe; exp_c = DW'(8'hFF); end
      S_AW0:  begin mem_we = 1'b1; mem_addr = probe; end
      S_AR0:  begin mem_re = 1'b1; mem_addr = probe; end
      S_ACHK: begin mem_re = 1'b1; exp_c = DW'(TEST_WORD); end
      S_SW:   begin mem_we = 1'b1; mem_addr = addr; mem_wdata = pat_of(psel); end
      S_SR:   begin mem_re = 1'b1; mem_addr = addr; exp_c = pat_of(psel); ph_c = 2'd1; end
      S_RW:   begin mem_we = 1'b1; mem_addr = lfsr; mem_wdata = seed; end
      S_RR:   begin mem_re = 1'b1; mem_addr = lfsr; exp_c = seed; ph_c = 2'd2; end
      S_CLR:  begin mem_we = 1'b1; mem_addr = addr; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; lfsr <= START; bk <= '0; psel <= '0; rcnt <= '0;
      chk_v <= 1'b0; chk_exp <= '0; chk_addr <= '0; chk_ph <= '0;
      par_seen <= 1'b0; skip_q <= 1'b0; done_q <= 1'b0; pass_q <= 1'b0;
      fph <= '0; fad <= '0;
    end else begin
      chk_v <= mem_re; chk_exp <= exp_c; chk_addr <= mem_addr; chk_ph <= ph_c;
      if (par_err && testing) par_seen <= 1'b1;
      if (mismatch) begin
        st <= S_DONE; done_q <= 1'b1; pass_q <= 1'b0;
        fph <= chk_ph; fad <= chk_addr; chk_v <= 1'b0;
      end else begin
        case (st)
          S_IDLE, S_DONE:
            if (start) begin
              done_q <= 1'b0; pass_q <= 1'b0; fph <= '0; fad <= '0;
              par_seen <= 1'b0; skip_q <= skip; addr <= '0; bk <= '0;
              psel <= '0; lfsr <= START; rcnt <= '0;
              st <= skip ? S_CLR : S_SENT;
            end
          S_SENT: st <= S_AW1;
          S_AW1:  st <= S_AR1;
          S_AR1:  st <= S_AW0;
          S_AW0:  st <= S_AR0;
          S_AR0:
            if (bk == BKW'(AW - 1)) st <= S_ACHK;
            else begin bk <= bk + 1'b1; st <= S_AW1; end
          S_ACHK: begin addr <= '0; st <= S_SW; end
          S_SW: begin
            addr <= addr + 1'b1;
            if (addr == LAST) st <= S_SR;
          end
          S_SR: begin
            addr <= addr + 1'b1;
            if (addr == LAST) begin
              if (psel == 2'd3) begin lfsr <= START; rcnt <= '0; st <= S_RW; end
              else begin psel <= psel + 1'b1; st <= S_SW; end
            end
          end
          S_RW: begin
            lfsr <= lfsr_nx; rcnt <= rcnt + 1'b1;
            if (rnd_end) begin lfsr <= START; rcnt <= '0; st <= S_RR; end
          end
          S_RR: begin
            lfsr <= lfsr_nx; rcnt <= rcnt + 1'b1;
            if (rnd_end) st <= S_PAR;
          end
          S_PAR:
            if (par_seen || par_err) begin
              st <= S_DONE; done_q <= 1'b1; pass_q <= 1'b0; fph <= 2'd3; fad <= '0;
            end else begin
              addr <= '0; st <= S_CLR;
            end
          S_CLR: begin
            addr <= addr + 1'b1;
            if (addr == LAST) begin st <= S_DONE; done_q <= 1'b1; pass_q <= 1'b1; end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we && !mem_re);

  assert_busy_excl_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(fail_phase) && $stable(fail_addr));

  assert_skip_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q && busy |-> !mem_re);

  assert_probe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AW1 || st == S_AW0) |-> $countones(mem_addr) == 1);

  assert_pass_after_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && pass |-> $past(mem_we) && $past(mem_wdata) == '0);

  assert_parity_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass && fail_phase == 2'd3 |-> fail_addr == '0);

endmodule

// File: tb/memtest_engine_test.sv
`timescale 1ns/1ps
module memtest_engine_test;
  localparam int AW = 8;
  localparam int N  = 256;
  localparam int NR = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, skip = 1'b0, par_err = 1'b0;
  logic mem_we, mem_re, busy, done, pass;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0] fail_phase;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0]  wa  [0:16383];
  logic [15:0] wdl [0:16383];
  logic [15:0] ram [0:N-1];
  logic [15:0] rdv;
  int   stuck_abit = -1, df_addr = -1, df_bit = 0, cpl_src = -1, cpl_dst = 0;
  logic fill_req = 1'b0;
  logic [15:0] fill_val = '0;

  always #2 clk = ~clk;

  memtest_engine #(.AW(AW), .DW(16), .N_RAND(NR)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .skip(skip), .par_err(par_err),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
    .fail_phase(fail_phase), .fail_addr(fail_addr));

  function automatic logic [7:0] eff(input logic [7:0] a);
    if (stuck_abit >= 0) return a & ~(8'd1 << stuck_abit);
    return a;
  endfunction

  function automatic logic [7:0] lfsr_step(input logic [7:0] s);
    return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < N; i++) ram[i] <= fill_val;
    end else if (mem_we) begin
      ram[eff(mem_addr)] <= mem_wdata;
      if (cpl_src >= 0 && int'(mem_addr) == cpl_src) ram[cpl_dst] <= mem_wdata;
      wa[wr_cnt % 16384]  = mem_addr;
      wdl[wr_cnt % 16384] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_re) begin
      rdv = ram[eff(mem_addr)];
      if (df_addr >= 0 && int'(eff(mem_addr)) == df_addr) rdv = rdv | (16'd1 << df_bit);
      mem_rdata <= rdv;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] v);
    @(negedge clk); fill_val = v; fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  task automatic no_faults();
    stuck_abit = -1; df_addr = -1; cpl_src = -1;
  endtask

  task automatic run(input logic sk, input int par_at);
    @(negedge clk); skip = sk; start = 1'b1;
    @(negedge clk); start = 1'b0; skip = 1'b0;
    for (int c = 0; c < 20000 && !done; c++) begin
      par_err = (c == par_at);
      @(negedge clk);
    end
    par_err = 1'b0;
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10: run never finished, actual done %0b expected 1", done);
    end
  endtask

  task automatic t_reset();
    chk("R1 done after reset", done, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 no access after reset", {mem_we, mem_re}, 0);
    repeat (3) @(negedge clk);
    chk("R1 idle stays quiet", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_pass();
    int w0, r0, bad;
    logic [7:0] s;
    no_faults(); fill(16'hDEAD);
    w0 = wr_cnt; r0 = rd_cnt;
    run(1'b0, -1);
    chk("R6 pass flag", {done, pass}, 2'b11);
    chk("R9 read count", rd_cnt - r0, 2*AW + 1 + 4*N + NR);
    chk("R6 write count", wr_cnt - w0, 1 + 2*AW + 4*N + NR + N);
    chk("R2 test word write", {wa[w0], wdl[w0]}, {8'h00, 16'hC35A});
    bad = 0;
    for (int k = 0; k < AW; k++) begin
      if (wa[w0+1+2*k] != 8'(1 << k) || wdl[w0+1+2*k] != 16'h00FF) bad++;
      if (wa[w0+2+2*k] != 8'(1 << k) || wdl[w0+2+2*k] != 16'h0000) bad++;
    end
    chk("R2 probe writes", bad, 0);
    bad = 0;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < N; a++) begin
        logic [15:0] pv;
        pv = (p == 0) ? 16'h8080 : (p == 1) ? 16'h5555 : (p == 2) ? 16'h3333 : 16'h0F0F;
        if (wa[w0+17+p*N+a] != 8'(a) || wdl[w0+17+p*N+a] != pv) bad++;
      end
    chk("R3 pattern order and sweep", bad, 0);
    bad = 0; s = 8'h01;
    for (int i = 0; i < NR; i++) begin
      if (wa[w0+17+4*N+i] != s || wdl[w0+17+4*N+i] != {8'h00, s}) bad++;
      s = lfsr_step(s);
    end
    chk("R4 random addresses and data", bad, 0);
    bad = 0;
    for (int a = 0; a < N; a++) begin
      if (wa[w0+17+4*N+NR+a] != 8'(a) || wdl[w0+17+4*N+NR+a] != 16'h0) bad++;
      if (ram[a] != 16'h0) bad++;
    end
    chk("R6 final clear", bad, 0);
    repeat (8) @(negedge clk);
    chk("R10 status held", {done, pass, busy}, 3'b110);
  endtask

  task automatic t_skip();
    int w0, r0, bad;
    no_faults(); fill(16'hBEEF);
    w0 = wr_cnt; r0 = rd_cnt;
    run(1'b1, -1);
    chk("R7 skip passes", {done, pass}, 2'b11);
    chk("R7 skip issues no read", rd_cnt - r0, 0);
    chk("R7 skip write count", wr_cnt - w0, N);
    bad = 0;
    for (int a = 0; a < N; a++) if (ram[a] != 16'h0) bad++;
    chk("R7 skip clears segment", bad, 0);
  endtask

  task automatic t_addr_stuck();
    int w0, r0;
    no_faults(); stuck_abit = 3; fill(16'h1111);
    run(1'b0, -1);
    chk("R2 stuck address line", {pass, fail_phase, fail_addr}, {1'b0, 2'd0, 8'h00});
    w0 = wr_cnt; r0 = rd_cnt;
    repeat (6) @(negedge clk);
    chk("R8 no access after fail", (wr_cnt - w0) + (rd_cnt - r0), 0);
  endtask

  task automatic t_probe_fault();
    no_faults(); df_addr = 16; df_bit = 9;
    run(1'b0, -1);
    chk("R2 probe word fault", {pass, fail_phase, fail_addr}, {1'b0, 2'd0, 8'd16});
  endtask

  task automatic t_pattern_fault();
    int w0;
    no_faults(); df_addr = 8'h37; df_bit = 7;
    w0 = wr_cnt;
    run(1'b0, -1);
    chk("R3 pattern fault", {pass, fail_phase, fail_addr}, {1'b0, 2'd1, 8'h37});
    chk("R8 stopped in second pattern", wr_cnt - w0, 1 + 2*AW + 2*N);
    chk("R8 memory left uncleared", ram[8'h80], 16'h5555);
  endtask

  task automatic t_random_fault();
    logic [7:0] s, y, x;
    s = 8'h01;
    for (int i = 0; i < 10; i++) begin
      if (i == 2) y = s;
      if (i == 9) x = s;
      s = lfsr_step(s);
    end
    no_faults(); cpl_src = int'(x); cpl_dst = int'(y);
    run(1'b0, -1);
    chk("R4 coupled word in random phase", {pass, fail_phase, fail_addr}, {1'b0, 2'd2, y});
  endtask

  task automatic t_parity();
    no_faults();
    @(negedge clk); par_err = 1'b1; @(negedge clk); par_err = 1'b0;
    run(1'b0, -1);
    chk("R5 idle parity ignored", {done, pass}, 2'b11);
    run(1'b0, 100);
    chk("R5 parity fail", {pass, fail_phase, fail_addr}, {1'b0, 2'd3, 8'h00});
    chk("R5 no clear after parity fail", ram[1], 16'h0001);
  endtask

  task automatic t_rerun();
    no_faults();
    run(1'b0, -1);
    chk("R10 rerun after fail", {done, pass, fail_phase, fail_addr}, {2'b11, 2'd0, 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pass();
    t_skip();
    t_addr_stuck();
    t_probe_fault();
    t_pattern_fault();
    t_random_fault();
    t_parity();
    t_rerun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #760000;
    tests++; fails++;
    $display("FAIL R10: watchdog expired, actual done %0b expected 1", done);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule